// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a bank of transmit mailboxes for a CAN controller and decides which pending mailbox is handed to the bit engine next. Each mailbox stores an identifier word, a control word (priority, remote flag, data length) and eight data bytes. Software controls it through an enable register, a direction register, a write-one-to-set request register, a write-one-to-clear acknowledge register and an interrupt mask.

While no frame is in flight, the arbiter looks at every mailbox in every cycle. It picks the eligible one with the largest 6-bit priority and offers its decoded frame on a valid/ready channel. After a handoff the channel is held idle until the engine reports the outcome. A success clears the request and sets the acknowledge flag. A retry leaves the request in place, so the mailbox competes again.

Top module: `can_txarb_top`

## Requirements
- R1: After a synchronous reset, no mailbox is enabled or requested, every mailbox is set to receive (direction bit 1), the acknowledge and mask registers are zero, `tx_valid` and `irq` are low and `irq_mb` is 0.
- R2: A mailbox takes part in selection only when its enable bit is 1, its direction bit is 0 (transmit) and its request bit is 1. `tx_valid` is high only when no frame is in flight and at least one mailbox is eligible.
- R3: The offered mailbox (`tx_mb`) is the eligible one with the largest priority value, taken from control word bits 13:8.
- R4: When two or more eligible mailboxes share the largest priority, the one with the highest index is offered.
- R5: A write to the request-set register sets every request bit whose mask bit is 1. Mask bits that are 0 leave their request bits unchanged.
- R6: After a cycle with `tx_valid` and `tx_ready` both high, `tx_valid` stays low until `tx_done` or `tx_retry` is seen.
- R7: `tx_done` while a frame is in flight clears that mailbox's request bit and sets its acknowledge bit. `tx_retry` without `tx_done` leaves both unchanged. In both cases selection resumes in the next cycle. If both are high, done wins.
- R8: A write to the acknowledge-clear register clears the acknowledge bits whose mask bit is 1. If a success sets the same bit in the same cycle, the bit ends up set. A request set and a success clear on the same bit in the same cycle leave the request set.
- R9: `irq` is high exactly when some mailbox has both its acknowledge bit and its mask bit set. `irq_mb` gives the highest such mailbox index, and 0 when there is none.
- R10: While `tx_valid` is high, `tx_data`, `tx_dlc` (control bits 3:0) and `tx_rtr` (control bit 4) come from the offered mailbox.
- R11: `tx_done` and `tx_retry` have no effect when no frame is in flight.
- R12: `tx_ext` is identifier bit 31. When it is 1, `tx_ident` is identifier bits 28:0. When it is 0, `tx_ident` is identifier bits 28:18, zero-extended to 29 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_wr | input | 1 | Write one mailbox's frame words |
| mb_wr_idx | input | 5 | Mailbox index for the frame write |
| mb_wr_id | input | 32 | Identifier word to store |
| mb_wr_ctrl | input | 32 | Control word to store (priority 13:8, remote 4, length 3:0) |
| mb_wr_data | input | 64 | Eight data bytes to store |
| en_wr | input | 1 | Load the enable register |
| en_wdata | input | 32 | New enable register value |
| dir_wr | input | 1 | Load the direction register |
| dir_wdata | input | 32 | New direction register value (1 = receive) |
| req_set_wr | input | 1 | Request-set strobe |
| req_set_mask | input | 32 | Request bits to set |
| ack_clr_wr | input | 1 | Acknowledge-clear strobe |
| ack_clr_mask | input | 32 | Acknowledge bits to clear |
| imask_wr | input | 1 | Load the interrupt mask |
| imask_wdata | input | 32 | New interrupt mask |
| tx_valid | output | 1 | A frame is offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered frame |
| tx_mb | output | 5 | Index of the offered mailbox |
| tx_ext | output | 1 | Offered frame uses an extended identifier |
| tx_ident | output | 29 | Offered frame's identifier, right-aligned |
| tx_rtr | output | 1 | Offered frame is a remote request |
| tx_dlc | output | 4 | Offered frame's data length code |
| tx_data | output | 64 | Offered frame's data bytes |
| tx_done | input | 1 | Frame in flight was sent successfully |
| tx_retry | input | 1 | Frame in flight was not sent; try again |
| req_flags | output | 32 | Request register |
| ack_flags | output | 32 | Acknowledge register |
| irq | output | 1 | Masked acknowledge interrupt |
| irq_mb | output | 5 | Highest mailbox behind the interrupt |

## Verification
The directed phase sets two mailboxes to the same priority and places a higher-priority mailbox in receive direction and another one disabled. The offered index therefore tells a true priority-plus-index choice apart from a fixed-index pick, and it also shows that the direction and enable gating work. A standard-format and an extended-format mailbox show the two identifier layouts. Retry, success, idle strobes and same-cycle clear/set collisions each show a different route through the request and acknowledge registers. A long random phase mixes writes, handoffs and outcomes. A behavioural model built from per-mailbox scans is compared with the design at every clock.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;

    localparam int ID_W     = 32;
    localparam int CTRL_W   = 32;
    localparam int DATA_W   = 64;
    localparam int PRIO_W   = 6;
    localparam int PRIO_LSB = 8;
    localparam int DLC_W    = 4;
    localparam int RTR_POS  = 4;
    localparam int IDE_POS  = 31;
    localparam int STD_LSB  = 18;
    localparam int STD_W    = 11;
    localparam int EXT_W    = 29;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } mb_frame_t;

    typedef struct packed {
        logic              ext;
        logic [EXT_W-1:0]  ident;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } tx_frame_t;

    function automatic prio_t prio_of(input logic [CTRL_W-1:0] c);
        return c[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic tx_frame_t decode_frame(input mb_frame_t f);
        tx_frame_t t;
        t.ext   = f.id[IDE_POS];
        t.ident = f.id[IDE_POS] ? f.id[EXT_W-1:0] : EXT_W'(f.id[STD_LSB +: STD_W]);
        t.rtr   = f.ctrl[RTR_POS];
        t.dlc   = f.ctrl[DLC_W-1:0];
        t.data  = f.data;
        return t;
    endfunction

endpackage

// File: rtl/can_txarb_store.sv
module can_txarb_store
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mb_wr,
    input  logic [IDX_W-1:0]         mb_wr_idx,
    input  mb_frame_t                mb_wr_frame,
    input  logic                     en_wr,
    input  logic [NUM_MB-1:0]        en_wdata,
    input  logic                     dir_wr,
    input  logic [NUM_MB-1:0]        dir_wdata,
    input  logic [IDX_W-1:0]         sel_idx,
    output logic [NUM_MB-1:0]        en_q,
    output logic [NUM_MB-1:0]        dir_q,
    output logic [NUM_MB*PRIO_W-1:0] prio_flat,
    output mb_frame_t                sel_frame
);

    mb_frame_t frame_q [NUM_MB];

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        always_ff @(posedge clk) begin
            if (rst)
                frame_q[g] <= '0;
            else if (mb_wr && mb_wr_idx == IDX_W'(g))
                frame_q[g] <= mb_wr_frame;
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_of(frame_q[g].ctrl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            dir_q <= '1;
        end else begin
            if (en_wr)  en_q  <= en_wdata;
            if (dir_wr) dir_q <= dir_wdata;
        end
    end

    assign sel_frame = frame_q[sel_idx];

endmodule

// File: rtl/can_txarb_pick.sv
module can_txarb_pick
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_MB-1:0]        elig,
    input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
    output logic                     any,
    output logic [IDX_W-1:0]         win
);

    prio_t best;

    // Ascending scan with >=: a later (higher) index wins an equal priority.
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (elig[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
                any  = 1'b1;
                best = prio_flat[i*PRIO_W +: PRIO_W];
                win  = IDX_W'(i);
            end
        end
    end

    p_win_eligible_r2: assert property (@(posedge clk) disable iff (rst)
        any |-> elig[win]);

    p_any_matches_r2: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> any);

endmodule

// File: rtl/can_txarb_irq.sv
module can_txarb_irq #(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_MB-1:0] ack,
    input  logic [NUM_MB-1:0] imask,
    output logic              irq,
    output logic [IDX_W-1:0]  irq_mb
);

    logic [NUM_MB-1:0] hit;

    always_comb begin
        hit    = ack & imask;
        irq    = |hit;
        irq_mb = '0;
        for (int i = 0; i < NUM_MB; i++)
            if (hit[i]) irq_mb = IDX_W'(i);
    end

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ack[irq_mb] && imask[irq_mb]));

endmodule

// File: rtl/can_txarb_top.sv
module can_txarb_top
    import can_txarb_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mb_wr,
    input  logic [IDX_W-1:0]   mb_wr_idx,
    input  logic [ID_W-1:0]    mb_wr_id,
    input  logic [CTRL_W-1:0]  mb_wr_ctrl,
    input  logic [DATA_W-1:0]  mb_wr_data,
    input  logic               en_wr,
    input  logic [NUM_MB-1:0]  en_wdata,
    input  logic               dir_wr,
    input  logic [NUM_MB-1:0]  dir_wdata,
    input  logic               req_set_wr,
    input  logic [NUM_MB-1:0]  req_set_mask,
    input  logic               ack_clr_wr,
    input  logic [NUM_MB-1:0]  ack_clr_mask,
    input  logic               imask_wr,
    input  logic [NUM_MB-1:0]  imask_wdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [IDX_W-1:0]   tx_mb,
    output logic               tx_ext,
    output logic [EXT_W-1:0]   tx_ident,
    output logic               tx_rtr,
    output logic [DLC_W-1:0]   tx_dlc,
    output logic [DATA_W-1:0]  tx_data,
    input  logic               tx_done,
    input  logic               tx_retry,
    output logic [NUM_MB-1:0]  req_flags,
    output logic [NUM_MB-1:0]  ack_flags,
    output logic               irq,
    output logic [IDX_W-1:0]   irq_mb
);

    logic [NUM_MB-1:0]        req_q, ack_q, imask_q, req_nxt, ack_nxt;
    logic [NUM_MB-1:0]        en_q, dir_q, elig;
    logic [NUM_MB*PRIO_W-1:0] prio_flat;
    logic                     busy_q, any, finish, give_up, handoff;
    logic [IDX_W-1:0]         lock_q, win;
    mb_frame_t                wr_frame, sel_frame;
    tx_frame_t                offer;

    assign wr_frame = '{id: mb_wr_id, ctrl: mb_wr_ctrl, data: mb_wr_data};

    can_txarb_store #(.NUM_MB(NUM_MB)) u_store (
        .clk, .rst, .mb_wr, .mb_wr_idx, .mb_wr_frame(wr_frame),
        .en_wr, .en_wdata, .dir_wr, .dir_wdata, .sel_idx(win),
        .en_q, .dir_q, .prio_flat, .sel_frame
    );

    assign elig = en_q & ~dir_q & req_q;

    can_txarb_pick #(.NUM_MB(NUM_MB)) u_pick (
        .clk, .rst, .elig, .prio_flat, .any, .win
    );

    can_txarb_irq #(.NUM_MB(NUM_MB)) u_irq (
        .clk, .rst, .ack(ack_q), .imask(imask_q), .irq, .irq_mb
    );

    assign tx_valid = !busy_q && any;
    assign handoff  = tx_valid && tx_ready;
    assign finish   = busy_q && tx_done;
    assign give_up  = busy_q && tx_retry && !tx_done;

    // Success clears first, software set applies on top; success set wins over clear.
    always_comb begin
        req_nxt = req_q;
        if (finish)     req_nxt[lock_q] = 1'b0;
        if (req_set_wr) req_nxt = req_nxt | req_set_mask;
        ack_nxt = ack_q;
        if (ack_clr_wr) ack_nxt = ack_nxt & ~ack_clr_mask;
        if (finish)     ack_nxt[lock_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            ack_q   <= '0;
            imask_q <= '0;
            busy_q  <= 1'b0;
            lock_q  <= '0;
        end else begin
            req_q <= req_nxt;
            ack_q <= ack_nxt;
            if (imask_wr) imask_q <= imask_wdata;
            if (finish || give_up) begin
                busy_q <= 1'b0;
            end else if (handoff) begin
                busy_q <= 1'b1;
                lock_q <= win;
            end
        end
    end

    assign offer     = decode_frame(sel_frame);
    assign tx_mb     = win;
    assign tx_ext    = offer.ext;
    assign tx_ident  = offer.ident;
    assign tx_rtr    = offer.rtr;
    assign tx_dlc    = offer.dlc;
    assign tx_data   = offer.data;
    assign req_flags = req_q;
    assign ack_flags = ack_q;

    p_set_bits_r5: assert property (@(posedge clk) disable iff (rst)
        req_set_wr |=> ((req_q & $past(req_set_mask)) == $past(req_set_mask)));

    p_lock_after_handoff_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);

    p_done_updates_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && tx_done && !(req_set_wr && req_set_mask[lock_q]))
        |=> (ack_q[$past(lock_q)] && !req_q[$past(lock_q)]));

    p_retry_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && tx_retry && !tx_done) |=> req_q[$past(lock_q)]);

    p_clear_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_wr && !busy_q) |=> ((ack_q & $past(ack_clr_mask)) == '0));

    p_idle_no_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !ack_clr_wr) |=> (ack_q == $past(ack_q)));

endmodule

// File: tb/sim_can_txarb_top.sv
module sim_can_txarb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mb_wr = 1'b0;
    logic [4:0]  mb_wr_idx = '0;
    logic [31:0] mb_wr_id = '0, mb_wr_ctrl = '0;
    logic [63:0] mb_wr_data = '0;
    logic        en_wr = 1'b0, dir_wr = 1'b0, req_set_wr = 1'b0, ack_clr_wr = 1'b0, imask_wr = 1'b0;
    logic [31:0] en_wdata = '0, dir_wdata = '0, req_set_mask = '0, ack_clr_mask = '0, imask_wdata = '0;
    logic        tx_ready = 1'b0, tx_done = 1'b0, tx_retry = 1'b0;
    logic        tx_valid, tx_ext, tx_rtr, irq;
    logic [4:0]  tx_mb, irq_mb;
    logic [28:0] tx_ident;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic [31:0] req_flags, ack_flags;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    always #10 clk = ~clk;

    can_txarb_top u0 (
        .clk, .rst, .mb_wr, .mb_wr_idx, .mb_wr_id, .mb_wr_ctrl, .mb_wr_data,
        .en_wr, .en_wdata, .dir_wr, .dir_wdata, .req_set_wr, .req_set_mask,
        .ack_clr_wr, .ack_clr_mask, .imask_wr, .imask_wdata,
        .tx_valid, .tx_ready, .tx_mb, .tx_ext, .tx_ident, .tx_rtr, .tx_dlc, .tx_data,
        .tx_done, .tx_retry, .req_flags, .ack_flags, .irq, .irq_mb
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_en, m_dir, m_req, m_ack, m_imask;
    logic [31:0] m_id [32];
    logic [31:0] m_ctrl [32];
    logic [63:0] m_data [32];
    bit          m_busy;
    int          m_lock;

    function automatic int m_pick();
        int best = -1;
        int bp = -1;
        for (int i = 31; i >= 0; i--) begin
            if (m_en[i] && !m_dir[i] && m_req[i] && int'(m_ctrl[i][13:8]) > bp) begin
                best = i;
                bp = int'(m_ctrl[i][13:8]);
            end
        end
        return best;
    endfunction

    always @(posedge clk) begin
        int  w;
        bit  hs, fin, rty;
        if (rst) begin
            m_en = '0; m_dir = '1; m_req = '0; m_ack = '0; m_imask = '0;
            m_busy = 1'b0; m_lock = 0;
            for (int i = 0; i < 32; i++) begin
                m_id[i] = '0; m_ctrl[i] = '0; m_data[i] = '0;
            end
        end else begin
            w   = m_pick();
            hs  = !m_busy && (w >= 0) && tx_ready;
            fin = m_busy && tx_done;
            rty = m_busy && tx_retry && !tx_done;
            if (mb_wr) begin
                m_id[mb_wr_idx] = mb_wr_id;
                m_ctrl[mb_wr_idx] = mb_wr_ctrl;
                m_data[mb_wr_idx] = mb_wr_data;
            end
            if (en_wr)    m_en = en_wdata;
            if (dir_wr)   m_dir = dir_wdata;
            if (imask_wr) m_imask = imask_wdata;
            if (fin) m_req[m_lock] = 1'b0;
            if (req_set_wr) m_req = m_req | req_set_mask;
            if (ack_clr_wr) m_ack = m_ack & ~ack_clr_mask;
            if (fin) m_ack[m_lock] = 1'b1;
            if (fin || rty) m_busy = 1'b0;
            else if (hs) begin
                m_busy = 1'b1;
                m_lock = w;
            end
        end
    end

    always @(negedge clk) begin
        int w;
        bit ev;
        logic [31:0] hit;
        logic [28:0] id_e;
        int top;
        if (compare_on) begin
            w  = m_pick();
            ev = !m_busy && (w >= 0);
            chk(tx_valid == ev, "R2 tx_valid vs model", 64'(tx_valid), 64'(ev));
            if (ev) begin
                chk(int'(tx_mb) == w, "R3 R4 winner vs model", 64'(tx_mb), 64'(w));
                id_e = m_id[w][31] ? m_id[w][28:0] : {18'b0, m_id[w][28:18]};
                chk(tx_ext == m_id[w][31] && tx_ident == id_e, "R12 identifier vs model",
                    64'({tx_ext, tx_ident}), 64'({m_id[w][31], id_e}));
                chk(tx_dlc == m_ctrl[w][3:0] && tx_rtr == m_ctrl[w][4] && tx_data == m_data[w],
                    "R10 frame fields vs model", tx_data, m_data[w]);
            end
            chk(req_flags == m_req, "R5 R7 request register vs model", 64'(req_flags), 64'(m_req));
            chk(ack_flags == m_ack, "R8 acknowledge register vs model", 64'(ack_flags), 64'(m_ack));
            hit = m_ack & m_imask;
            top = 0;
            for (int i = 0; i < 32; i++) if (hit[i]) top = i;
            chk(irq == (hit != 0) && int'(irq_mb) == top, "R9 interrupt vs model",
                64'({irq, irq_mb}), 64'({(hit != 0), 5'(top)}));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic write_mb(input int idx, input logic [31:0] id, input logic [31:0] ctrl, input logic [63:0] data);
        @(negedge clk);
        mb_wr = 1'b1; mb_wr_idx = 5'(idx); mb_wr_id = id; mb_wr_ctrl = ctrl; mb_wr_data = data;
        @(negedge clk);
        mb_wr = 1'b0;
    endtask

    task automatic write_en_dir(input logic [31:0] en, input logic [31:0] dir);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = en; dir_wr = 1'b1; dir_wdata = dir;
        @(negedge clk);
        en_wr = 1'b0; dir_wr = 1'b0;
    endtask

    task automatic set_req(input logic [31:0] m);
        @(negedge clk);
        req_set_wr = 1'b1; req_set_mask = m;
        @(negedge clk);
        req_set_wr = 1'b0;
    endtask

    task automatic clr_ack(input logic [31:0] m);
        @(negedge clk);
        ack_clr_wr = 1'b1; ack_clr_mask = m;
        @(negedge clk);
        ack_clr_wr = 1'b0;
    endtask

    task automatic set_imask(input logic [31:0] m);
        @(negedge clk);
        imask_wr = 1'b1; imask_wdata = m;
        @(negedge clk);
        imask_wr = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic outcome(input bit done, input bit retry);
        @(negedge clk);
        tx_done = done; tx_retry = retry;
        @(negedge clk);
        tx_done = 1'b0; tx_retry = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        logic [31:0] txm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid && req_flags == 0 && ack_flags == 0 && !irq && irq_mb == 0,
            "R1 reset state", 64'({tx_valid, irq, irq_mb}), 64'd0);
        compare_on = 1'b1;

        write_mb(3,  32'h123 << 18, 32'h0508, 64'h0011_2233_4455_6677);
        write_mb(7,  32'h456 << 18, 32'h0512, 64'hA5A5_0000_0000_0000);
        write_mb(10, 32'h07F << 18, 32'h0201, 64'h1);
        write_mb(20, 32'h001 << 18, 32'h0908, 64'h2);
        write_mb(1,  32'h002 << 18, 32'h3F08, 64'h3);
        txm = (32'h1 << 1) | (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 10);
        write_en_dir(txm | (32'h1 << 20), ~(txm));
        write_en_dir(txm & ~32'h2 | (32'h1 << 20), ~txm);   // mailbox 1: transmit but disabled
        set_req(txm | (32'h1 << 20));
        chk(req_flags == (txm | (32'h1 << 20)), "R5 request bits set", 64'(req_flags), 64'(txm | (32'h1 << 20)));
        set_req(32'h0);
        chk(req_flags == (txm | (32'h1 << 20)), "R5 zero mask has no effect", 64'(req_flags), 64'(txm | (32'h1 << 20)));
        chk(tx_valid && tx_mb == 7, "R4 tie goes to higher index", 64'(tx_mb), 64'd7);
        chk(tx_ident == 29'h456 && !tx_ext && tx_rtr && tx_dlc == 4'd2, "R12 standard identifier",
            64'(tx_ident), 64'h456);

        take();
        chk(!tx_valid, "R6 locked after handoff", 64'(tx_valid), 64'd0);
        repeat (3) @(negedge clk);
        chk(!tx_valid, "R6 still locked", 64'(tx_valid), 64'd0);
        outcome(1'b1, 1'b0);
        chk(ack_flags == 32'h80 && !req_flags[7], "R7 success sets ack and clears request",
            64'(ack_flags), 64'h80);
        chk(tx_valid && tx_mb == 3, "R3 larger priority beats lower", 64'(tx_mb), 64'd3);

        take();
        outcome(1'b0, 1'b1);
        chk(req_flags[3] && !ack_flags[3] && tx_valid && tx_mb == 3, "R7 retry keeps request",
            64'(req_flags), 64'(req_flags | 32'h8));

        set_imask(32'h88);
        take();
        outcome(1'b1, 1'b0);
        chk(irq && irq_mb == 7, "R9 highest masked ack", 64'(irq_mb), 64'd7);
        clr_ack(32'h80);
        chk(ack_flags == 32'h8 && irq && irq_mb == 3, "R8 clear one ack", 64'(ack_flags), 64'h8);

        write_mb(12, 32'h8000_0000 | 32'h1ABC_DEF0, 32'h3F08, 64'hDEAD_BEEF_0123_4567);
        write_en_dir(txm & ~32'h2 | (32'h1 << 20) | (32'h1 << 12), ~(txm | (32'h1 << 12)));
        set_req(32'h1 << 12);
        chk(tx_valid && tx_mb == 12 && tx_ext && tx_ident == 29'h1ABC_DEF0 && tx_data == 64'hDEAD_BEEF_0123_4567,
            "R12 extended identifier", 64'(tx_ident), 64'h1ABC_DEF0);
        write_en_dir(txm & ~32'h2 | (32'h1 << 20), ~(txm | (32'h1 << 12)));
        chk(tx_valid && tx_mb == 10, "R2 disabled mailbox drops out", 64'(tx_mb), 64'd10);

        take();
        outcome(1'b1, 1'b0);
        chk(!tx_valid, "R2 nothing eligible", 64'(tx_valid), 64'd0);
        outcome(1'b1, 1'b0);
        outcome(1'b0, 1'b1);
        chk(ack_flags == 32'h408 && req_flags == ((32'h1 << 12) | (32'h1 << 20) | 32'h2),
            "R11 idle outcome ignored", 64'(ack_flags), 64'h408);

        write_en_dir(txm & ~32'h2 | (32'h1 << 12), ~(txm | (32'h1 << 12)));
        take();
        @(negedge clk);
        tx_done = 1'b1; ack_clr_wr = 1'b1; ack_clr_mask = 32'h1 << 12;
        req_set_wr = 1'b1; req_set_mask = 32'h1 << 12;
        @(negedge clk);
        tx_done = 1'b0; ack_clr_wr = 1'b0; req_set_wr = 1'b0;
        chk(ack_flags[12] && req_flags[12], "R8 same-cycle success beats clear and set beats success",
            64'({ack_flags[12], req_flags[12]}), 64'h3);

        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            mb_wr      = ($urandom % 8) == 0;
            mb_wr_idx  = 5'($urandom);
            mb_wr_id   = $urandom;
            mb_wr_ctrl = {18'b0, 6'($urandom % 4), 3'b0, 5'($urandom)};
            mb_wr_data = {$urandom, $urandom};
            en_wr      = ($urandom % 16) == 0;
            en_wdata   = $urandom | $urandom;
            dir_wr     = ($urandom % 16) == 0;
            dir_wdata  = $urandom & $urandom;
            req_set_wr = ($urandom % 4) == 0;
            req_set_mask = $urandom & $urandom;
            ack_clr_wr = ($urandom % 4) == 0;
            ack_clr_mask = $urandom;
            imask_wr   = ($urandom % 16) == 0;
            imask_wdata = $urandom;
            tx_ready   = $urandom % 2;
            tx_done    = ($urandom % 4) == 0;
            tx_retry   = ($urandom % 8) == 0;
        end
        @(negedge clk);
        mb_wr = 0; en_wr = 0; dir_wr = 0; req_set_wr = 0; ack_clr_wr = 0; imask_wr = 0;
        tx_ready = 0; tx_done = 0; tx_retry = 0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule